// File: doc/BRIEF.md
# Exclusive-Aware Request ID Tracker

This block sits between a data-cache front end and an ID-tagged read/write request path. For every miss or uncached request it chooses the ID placed on the outgoing bus and records the transaction in a small table until the response returns. The response then goes back to the front end with the ID the front end used.

Front-end IDs are wider than bus IDs. A normal request keeps its ID when that ID fits the bus width and no other original ID is using it. It reuses the outgoing ID of an outstanding request that has the same original ID, so the bus keeps those requests in order. In every other case it takes the lowest free bus ID as a substitute. Requests with different IDs therefore get different bus IDs, and their responses may come back in any order.

Exclusive requests never pass through the cache. They go out as uncached, keep their ID unchanged, and are held in a separate one-entry exclusive slot. That slot is a two-state machine: `XS_FREE` moves to `XS_BUSY` on an accepted exclusive request (transition *claim*). `XS_BUSY` moves back to `XS_FREE` on the matching response (transition *retire*).

Top module: `excl_id_tracker`

## Requirements
- R1: After reset no request or response is presented on either side, and an incoming request with no outstanding traffic is accepted whenever `bus_ready` is high.
- R2: An exclusive request goes out with `bus_excl`=1 and `bus_id` equal to its incoming ID. Exclusive IDs must fit the bus width, meaning their upper bits are zero.
- R3: `bus_nocache` is 1 for every exclusive request. For a normal request it follows `req_nocache`.
- R4: A normal request goes out with its own ID when three conditions hold: its ID is below 2^OUT_IDW, no outstanding request with the same original ID exists, and that value is not an outgoing ID in use.
- R5: A normal request whose ID is 2^OUT_IDW or more gets the lowest bus ID value not in use.
- R6: A normal request whose ID fits but whose value is in use by a different original ID gets the lowest bus ID value not in use.
- R7: A normal request with the same original ID as an outstanding normal request goes out with that request's outgoing ID.
- R8: With NENT normal requests outstanding, a further normal request is held: `req_ready`=0 and `bus_valid`=0. A response frees one entry.
- R9: A response on bus ID X is presented upstream in the same cycle with the original ID that was mapped to X. `up_excl` is 1 only for the exclusive response. `rsp_ready` equals `up_ready`.
- R10: While the exclusive slot is busy, a second exclusive request is held, and so is a normal request whose ID equals the exclusive request's ID.
- R11: An exclusive request is held while any outstanding normal request has that same original ID or uses that value as its outgoing ID.
- R12: Responses on different bus IDs may arrive in any order, and each one restores its own original ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Front-end request valid |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_id | input | IN_IDW | Front-end (original) ID |
| req_excl | input | 1 | Request is exclusive |
| req_nocache | input | 1 | Normal request is uncached |
| bus_valid | output | 1 | Outgoing request valid |
| bus_ready | input | 1 | Outgoing path can take a request |
| bus_id | output | OUT_IDW | Outgoing ID |
| bus_excl | output | 1 | Outgoing request is exclusive |
| bus_nocache | output | 1 | Outgoing request bypasses caching |
| rsp_valid | input | 1 | Bus response valid |
| rsp_ready | output | 1 | Bus response taken |
| rsp_id | input | OUT_IDW | Bus response ID |
| up_valid | output | 1 | Response to front end valid |
| up_ready | input | 1 | Front end takes the response |
| up_id | output | IN_IDW | Restored original ID |
| up_excl | output | 1 | Response belongs to the exclusive request |

## Verification
A corrupted mapping entry shows up the moment its response returns, as a wrong `up_id`. It can also show up earlier, on the next request that consults the entry: a wrong reuse, pass-through or substitute value on `bus_id`. A stuck valid bit appears as a spurious stall once the table fills, or as a busy exclusive slot that never frees. An entry dropped too early shows as a bus ID handed out twice to different originals. The bench therefore checks the outgoing ID on every request and scoreboards every response, so each of these faults surfaces within one request or one response.

// File: rtl/eit_pkg.sv
package eit_pkg;
    typedef enum logic {
        XS_FREE = 1'b0,
        XS_BUSY = 1'b1
    } xslot_state_e;

    typedef enum logic [1:0] {
        RT_REUSE = 2'd0,
        RT_PASS  = 2'd1,
        RT_SUB   = 2'd2
    } route_e;
endpackage

// File: rtl/eit_out_table.sv
module eit_out_table #(
    parameter int NENT    = 4,
    parameter int IN_IDW  = 6,
    parameter int OUT_IDW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  alloc,
    input  logic [IN_IDW-1:0]     alloc_orig,
    input  logic [OUT_IDW-1:0]    alloc_out,
    input  logic                  rel,
    input  logic [OUT_IDW-1:0]    rel_out,
    input  logic [IN_IDW-1:0]     q_orig,
    output logic                  full,
    output logic                  same_hit,
    output logic [OUT_IDW-1:0]    same_out,
    output logic [(1<<OUT_IDW)-1:0] used_mask,
    output logic                  rel_hit,
    output logic [IN_IDW-1:0]     rel_orig,
    output logic                  excl_clash
);
    localparam int IDX_W = (NENT > 1) ? $clog2(NENT) : 1;
    localparam int NOUT  = 1 << OUT_IDW;

    logic [NENT-1:0]    vld_q;
    logic [IN_IDW-1:0]  orig_q [NENT];
    logic [OUT_IDW-1:0] out_q  [NENT];

    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rel_idx;
    logic [NENT-1:0]  orig_eq;
    logic [NENT-1:0]  out_eq_q;
    logic [NENT-1:0]  rel_eq;

    genvar g;
    generate
        for (g = 0; g < NENT; g++) begin : g_cmp
            assign orig_eq[g]  = vld_q[g] && (orig_q[g] == q_orig);
            assign out_eq_q[g] = vld_q[g] && (out_q[g] == q_orig[OUT_IDW-1:0]);
            assign rel_eq[g]   = vld_q[g] && (out_q[g] == rel_out);
        end
    endgenerate

    assign full       = &vld_q;
    assign same_hit   = |orig_eq;
    assign rel_hit    = |rel_eq;
    assign excl_clash = |(orig_eq | out_eq_q);

    always_comb begin
        free_idx = '0;
        rel_idx  = '0;
        same_out = '0;
        for (int i = NENT - 1; i >= 0; i--) begin
            if (!vld_q[i])  free_idx = IDX_W'(i);
            if (rel_eq[i])  rel_idx  = IDX_W'(i);
            if (orig_eq[i]) same_out = out_q[i];
        end
        rel_orig = orig_q[rel_idx];
    end

    always_comb begin
        used_mask = '0;
        for (int i = 0; i < NENT; i++) begin
            for (int v = 0; v < NOUT; v++) begin
                if (vld_q[i] && (out_q[i] == OUT_IDW'(v))) used_mask[v] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < NENT; i++) begin
                orig_q[i] <= '0;
                out_q[i]  <= '0;
            end
        end else begin
            if (rel && rel_hit) vld_q[rel_idx] <= 1'b0;
            if (alloc && !full) begin
                vld_q[free_idx]  <= 1'b1;
                orig_q[free_idx] <= alloc_orig;
                out_q[free_idx]  <= alloc_out;
            end
        end
    end

    a_r8_no_alloc_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> !full);
    a_r9_release_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
        rel |-> rel_hit);
    a_r8_full_drops_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rel && !alloc) |=> !full);
endmodule

// File: rtl/eit_id_pick.sv
module eit_id_pick #(
    parameter int IN_IDW  = 6,
    parameter int OUT_IDW = 4
) (
    input  logic [IN_IDW-1:0]        q_orig,
    input  logic                     same_hit,
    input  logic [OUT_IDW-1:0]       same_out,
    input  logic [(1<<OUT_IDW)-1:0]  used_mask,
    output logic [OUT_IDW-1:0]       pick_out,
    output eit_pkg::route_e          route
);
    import eit_pkg::*;
    localparam int NOUT = 1 << OUT_IDW;

    logic               fits;
    logic [OUT_IDW-1:0] low_free;

    assign fits = (q_orig >> OUT_IDW) == '0;

    always_comb begin
        low_free = '0;
        for (int v = NOUT - 1; v >= 0; v--) begin
            if (!used_mask[v]) low_free = OUT_IDW'(v);
        end
    end

    always_comb begin
        if (same_hit) begin
            route    = RT_REUSE;
            pick_out = same_out;
        end else if (fits && !used_mask[q_orig[OUT_IDW-1:0]]) begin
            route    = RT_PASS;
            pick_out = q_orig[OUT_IDW-1:0];
        end else begin
            route    = RT_SUB;
            pick_out = low_free;
        end
    end

    always_comb begin
        if (route == RT_SUB) a_r6_sub_is_free: assert (!used_mask[pick_out]);
    end
endmodule

// File: rtl/eit_excl_slot.sv
module eit_excl_slot #(
    parameter int IN_IDW = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              claim,
    input  logic [IN_IDW-1:0] claim_id,
    input  logic              retire,
    output logic              busy,
    output logic [IN_IDW-1:0] held_id
);
    import eit_pkg::*;

    xslot_state_e state_q, state_d;
    logic [IN_IDW-1:0] id_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XS_FREE: if (claim)  state_d = XS_BUSY;
            XS_BUSY: if (retire) state_d = XS_FREE;
            default: state_d = XS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XS_FREE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == XS_FREE && claim) id_q <= claim_id;
        end
    end

    always_comb begin
        busy    = (state_q == XS_BUSY);
        held_id = id_q;
    end

    a_r10_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
        claim |-> state_q == XS_FREE);
    a_r9_retire_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> state_q == XS_BUSY);
    a_r10_claim_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !retire) |=> busy);
endmodule

// File: rtl/excl_id_tracker.sv
module excl_id_tracker #(
    parameter int NENT    = 4,
    parameter int IN_IDW  = 6,
    parameter int OUT_IDW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [IN_IDW-1:0]  req_id,
    input  logic               req_excl,
    input  logic               req_nocache,
    output logic               bus_valid,
    input  logic               bus_ready,
    output logic [OUT_IDW-1:0] bus_id,
    output logic               bus_excl,
    output logic               bus_nocache,
    input  logic               rsp_valid,
    output logic               rsp_ready,
    input  logic [OUT_IDW-1:0] rsp_id,
    output logic               up_valid,
    input  logic               up_ready,
    output logic [IN_IDW-1:0]  up_id,
    output logic               up_excl
);
    import eit_pkg::*;
    localparam int NOUT = 1 << OUT_IDW;

    logic               tbl_full, tbl_same_hit, tbl_rel_hit, tbl_clash;
    logic [OUT_IDW-1:0] tbl_same_out, pick_out;
    logic [NOUT-1:0]    tbl_used, all_used;
    logic [IN_IDW-1:0]  tbl_rel_orig, ex_id;
    logic               ex_busy;
    route_e             route;

    logic stall, req_fire, rsp_fire, rsp_is_excl;
    logic alloc_n, claim_x, rel_n, retire_x;

    always_comb begin
        all_used = tbl_used;
        if (ex_busy) all_used[ex_id[OUT_IDW-1:0]] = 1'b1;
    end

    always_comb begin
        if (req_excl) stall = ex_busy || tbl_clash;
        else          stall = tbl_full || (ex_busy && (req_id == ex_id));
    end

    assign req_ready   = bus_ready && !stall;
    assign bus_valid   = req_valid && !stall;
    assign bus_id      = req_excl ? req_id[OUT_IDW-1:0] : pick_out;
    assign bus_excl    = req_excl;
    assign bus_nocache = req_excl | req_nocache;
    assign req_fire    = req_valid && req_ready;
    assign alloc_n     = req_fire && !req_excl;
    assign claim_x     = req_fire && req_excl;

    assign rsp_is_excl = ex_busy && (rsp_id == ex_id[OUT_IDW-1:0]);
    assign rsp_ready   = up_ready;
    assign up_valid    = rsp_valid;
    assign up_excl     = rsp_is_excl;
    assign up_id       = rsp_is_excl ? ex_id : tbl_rel_orig;
    assign rsp_fire    = rsp_valid && up_ready;
    assign rel_n       = rsp_fire && !rsp_is_excl;
    assign retire_x    = rsp_fire && rsp_is_excl;

    eit_out_table #(.NENT(NENT), .IN_IDW(IN_IDW), .OUT_IDW(OUT_IDW)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (alloc_n),
        .alloc_orig (req_id),
        .alloc_out  (pick_out),
        .rel        (rel_n),
        .rel_out    (rsp_id),
        .q_orig     (req_id),
        .full       (tbl_full),
        .same_hit   (tbl_same_hit),
        .same_out   (tbl_same_out),
        .used_mask  (tbl_used),
        .rel_hit    (tbl_rel_hit),
        .rel_orig   (tbl_rel_orig),
        .excl_clash (tbl_clash)
    );

    eit_id_pick #(.IN_IDW(IN_IDW), .OUT_IDW(OUT_IDW)) u_pick (
        .q_orig    (req_id),
        .same_hit  (tbl_same_hit),
        .same_out  (tbl_same_out),
        .used_mask (all_used),
        .pick_out  (pick_out),
        .route     (route)
    );

    eit_excl_slot #(.IN_IDW(IN_IDW)) u_xslot (
        .clk      (clk),
        .rst_n    (rst_n),
        .claim    (claim_x),
        .claim_id (req_id),
        .retire   (retire_x),
        .busy     (ex_busy),
        .held_id  (ex_id)
    );

    a_r2_excl_id_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_excl) |-> (req_id >> OUT_IDW) == '0);
    a_r2_excl_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_excl) |-> bus_id == req_id[OUT_IDW-1:0]);
    a_r3_excl_uncached: assert property (@(posedge clk) disable iff (!rst_n)
        bus_excl |-> bus_nocache);
    a_r11_claim_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        claim_x |=> ex_busy);
    a_r7_reuse_route: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_n && tbl_same_hit) |-> route == RT_REUSE);
    a_r9_response_matched: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fire |-> (rsp_is_excl || tbl_rel_hit));
endmodule

// File: tb/excl_id_tracker_bench.sv
module excl_id_tracker_bench;
    localparam int IN_IDW  = 6;
    localparam int OUT_IDW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_excl = 1'b0, req_nocache = 1'b0;
    logic [IN_IDW-1:0] req_id = '0;
    logic bus_ready = 1'b1;
    logic rsp_valid = 1'b0, up_ready = 1'b1;
    logic [OUT_IDW-1:0] rsp_id = '0;
    logic req_ready, bus_valid, bus_excl, bus_nocache, rsp_ready, up_valid, up_excl;
    logic [OUT_IDW-1:0] bus_id;
    logic [IN_IDW-1:0]  up_id;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct { int id; int excl; string tag; } exp_t;
    exp_t sb_q[$];

    always #5 clk = ~clk;

    excl_id_tracker #(.NENT(4), .IN_IDW(IN_IDW), .OUT_IDW(OUT_IDW)) u_excl_id_tracker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_excl(req_excl), .req_nocache(req_nocache),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_id(bus_id),
        .bus_excl(bus_excl), .bus_nocache(bus_nocache),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_id(rsp_id),
        .up_valid(up_valid), .up_ready(up_ready), .up_id(up_id), .up_excl(up_excl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int id, input bit ex, input bit nc, input int exp_out,
                         input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_id = IN_IDW'(id); req_excl = ex; req_nocache = nc;
        #1;
        chk({tag, " accept"}, int'(req_ready && bus_valid), 1);
        chk({tag, " bus_id"}, int'(bus_id), exp_out);
        chk({tag, " bus_excl"}, int'(bus_excl), int'(ex));
        chk({tag, " bus_nocache"}, int'(bus_nocache), int'(ex | nc));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_excl = 1'b0; req_nocache = 1'b0;
    endtask

    task automatic held(input int id, input bit ex, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_id = IN_IDW'(id); req_excl = ex; req_nocache = 1'b0;
        #1;
        chk({tag, " req_ready"}, int'(req_ready), 0);
        chk({tag, " bus_valid"}, int'(bus_valid), 0);
        @(negedge clk);
        req_valid = 1'b0; req_excl = 1'b0;
    endtask

    task automatic respond(input int out, input int exp_orig, input bit exp_ex,
                           input string tag);
        exp_t e;
        e.id = exp_orig; e.excl = int'(exp_ex); e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
        rsp_valid = 1'b1; rsp_id = OUT_IDW'(out);
        @(negedge clk);
        rsp_valid = 1'b0;
    endtask

    // Monitor: pops the scoreboard on each accepted upstream response
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && up_valid && up_ready) begin
                if (sb_q.size() == 0) begin
                    chk("R9 unexpected response", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk({e.tag, " up_id"}, int'(up_id), e.id);
                    chk({e.tag, " up_excl"}, int'(up_excl), e.excl);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 reset bus_valid", int'(bus_valid), 0);
        chk("R1 reset up_valid", int'(up_valid), 0);
        chk("R1 reset req_ready", int'(req_ready), 1);

        issue(5,  0, 0, 5, "R4 R3 pass-through id5");
        issue(40, 0, 0, 0, "R5 wide id40");
        issue(0,  0, 0, 1, "R6 clash id0");
        issue(40, 0, 0, 0, "R7 reuse id40");
        held(9, 0, "R8 table full");
        respond(5, 5, 0, "R9 restore id5");
        issue(9,  0, 1, 9, "R8 R3 after free id9");

        @(negedge clk);
        up_ready = 1'b0;
        #1;
        chk("R9 rsp_ready follows up_ready", int'(rsp_ready), 0);
        up_ready = 1'b1;

        respond(1, 0,  0, "R12 out1 first");
        respond(0, 40, 0, "R12 out0 a");
        respond(0, 40, 0, "R12 out0 b");
        respond(9, 9,  0, "R12 out9");

        issue(3, 1, 0, 3, "R2 R3 excl id3");
        held(7, 1, "R10 second excl");
        held(3, 0, "R10 normal same id");
        issue(12, 0, 0, 12, "R4 id12 during excl");
        respond(3, 3, 1, "R9 R2 excl response");
        held(12, 1, "R11 excl orig clash");
        issue(50, 0, 0, 0, "R5 id50");
        held(0, 1, "R11 excl out clash");
        respond(12, 12, 0, "R12 out12");
        respond(0, 50, 0, "R12 out0");
        issue(0, 1, 0, 0, "R2 excl id0");
        respond(0, 0, 1, "R9 excl id0 response");

        repeat (3) @(negedge clk);
        chk("R9 scoreboard drained", sb_q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule